// File: doc/BRIEF.md
# Multi-Channel Variable-Length Result Serializer

This block sends signed time-stamp results out over serial lines. There are several independent channels, four by default, and they all run on one shared clock. Each channel has a parallel input with a valid/ready handshake, an active-low framing strobe and a single serial data line. When a channel accepts a result, it pulls its strobe low and sends one tag bit. The tag is 0, which marks the data as valid. The channel then sends the low bits of the two's-complement result, least-significant bit first, so the sign bit goes out last.

A three-bit length code arrives with each result and sets how many data bits the frame carries: 8, 16, 24, 32 or 40. The code and the result are captured at the moment the handshake completes. After the last data bit the strobe goes high and stays high for at least two cycles. The channel raises ready again in the second of those cycles, so a producer that holds valid high gets frames back to back with exactly two idle strobe cycles between them. Each channel runs on its own, and one channel stalling does not affect the others.

Top module: `rs_frame_tx`

## Requirements
- R1: While reset is asserted and right after it, every strobe is high (1), every data line is 0 and every ready is 1.
- R2: A result is taken on a rising clock edge where valid and ready are both 1. In the next cycle the strobe is low and the data line carries the tag value 0. A strobe never falls unless a result was taken.
- R3: After the tag, result bits 0 up to L-1 go out one per cycle with bit 0 first, where L is the field length. Bit L-1, the sign, is the last data bit.
- R4: The length code sets L as follows: 0 gives 8, 1 gives 16, 2 gives 24, 3 gives 32, and codes 4, 5, 6 and 7 all give 40.
- R5: The strobe stays low for exactly L+1 cycles (tag plus data). After that it stays high for at least two cycles.
- R6: Ready is 0 from the accepting edge until the strobe has been high for one cycle. It is 1 in the second high cycle and stays 1 after that while the channel is idle. A producer that holds valid high therefore sees exactly two high strobe cycles between frames.
- R7: The length code and the result are captured at acceptance. Changing either input during a frame has no effect on that frame's bits or length.
- R8: A data line is 0 in every cycle in which its strobe is high.
- R9: Channels are independent. Each one's handshake, framing and output depend only on its own inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared serial clock; outputs change on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | NUM_CH | Per-channel result valid |
| in_ready | output | NUM_CH | Per-channel ready to accept a result |
| in_result | input | NUM_CH*RES_W | Per-channel two's-complement result, channel c at bits c*RES_W upward |
| in_len | input | NUM_CH*CODE_W | Per-channel length code, channel c at bits c*CODE_W upward |
| ser_strobe_n | output | NUM_CH | Per-channel active-low frame strobe |
| ser_data | output | NUM_CH | Per-channel serial data |

## Verification
If a result is taken at edge E, the tag appears in the cycle after E, data bit k appears k+1 cycles after E, the strobe rises L+1 cycles after E, and ready returns L+2 cycles after E. The bench changes its inputs and samples every output at the falling clock edge. Each frame is rebuilt one cycle at a time from what the bench sees on the strobe and data lines, so every check compares against the cycle in which the result is due and never depends on the order of events at the rising edge. Ready is compared every cycle with a value the bench derives from how long the strobe has been high. The expected length and bits come from a bench model of the length code, applied to a record the bench stores at each handshake.

// File: rtl/rs_frame_pkg.sv
package rs_frame_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_TAG  = 2'd1,
        ST_DATA = 2'd2,
        ST_GAP  = 2'd3
    } lane_st_e;
endpackage

// File: rtl/rs_len_decode.sv
module rs_len_decode #(
    parameter int RES_W  = 40,
    parameter int CODE_W = 3,
    parameter int STEP   = 8,
    parameter int CNT_W  = $clog2(RES_W + 1)
) (
    input  logic [CODE_W-1:0] code_i,
    output logic [CNT_W-1:0]  len_o
);
    localparam int SIZES = RES_W / STEP;

    // Codes below SIZES pick (code+1)*STEP; all larger codes pick the full width.
    always_comb begin
        if (int'(code_i) < SIZES) begin
            len_o = CNT_W'((int'(code_i) + 1) * STEP);
        end else begin
            len_o = CNT_W'(RES_W);
        end
    end
endmodule

// File: rtl/rs_lane.sv
module rs_lane
    import rs_frame_pkg::*;
#(
    parameter int RES_W  = 40,
    parameter int CODE_W = 3,
    parameter int STEP   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    output logic              ready_o,
    input  logic [RES_W-1:0]  result_i,
    input  logic [CODE_W-1:0] code_i,
    output logic              strb_n_o,
    output logic              dat_o
);
    localparam int CNT_W = $clog2(RES_W + 1);

    typedef struct packed {
        lane_st_e         st;
        logic             strb_n;
        logic             dat;
        logic [RES_W-1:0] sh;
        logic [CNT_W-1:0] left;
        logic             gap2;
    } lane_t;

    lane_t            lane_d, lane_q;
    logic [CNT_W-1:0] len_w;
    logic             accept_w;

    rs_len_decode #(
        .RES_W (RES_W),
        .CODE_W(CODE_W),
        .STEP  (STEP),
        .CNT_W (CNT_W)
    ) u_len (
        .code_i(code_i),
        .len_o (len_w)
    );

    assign ready_o  = (lane_q.st == ST_IDLE) || ((lane_q.st == ST_GAP) && lane_q.gap2);
    assign accept_w = valid_i && ready_o;
    assign strb_n_o = lane_q.strb_n;
    assign dat_o    = lane_q.dat;

    always_comb begin
        lane_d = lane_q;
        unique case (lane_q.st)
            ST_IDLE: begin
                if (accept_w) begin
                    lane_d.st     = ST_TAG;
                    lane_d.strb_n = 1'b0;
                    lane_d.dat    = 1'b0;
                    lane_d.sh     = result_i;
                    lane_d.left   = len_w;
                    lane_d.gap2   = 1'b0;
                end
            end
            ST_TAG: begin
                lane_d.st   = ST_DATA;
                lane_d.dat  = lane_q.sh[0];
                lane_d.sh   = lane_q.sh >> 1;
                lane_d.left = lane_q.left - CNT_W'(1);
            end
            ST_DATA: begin
                if (lane_q.left == '0) begin
                    lane_d.st     = ST_GAP;
                    lane_d.strb_n = 1'b1;
                    lane_d.dat    = 1'b0;
                    lane_d.gap2   = 1'b0;
                end else begin
                    lane_d.dat  = lane_q.sh[0];
                    lane_d.sh   = lane_q.sh >> 1;
                    lane_d.left = lane_q.left - CNT_W'(1);
                end
            end
            ST_GAP: begin
                if (!lane_q.gap2) begin
                    lane_d.gap2 = 1'b1;
                end else if (accept_w) begin
                    lane_d.st     = ST_TAG;
                    lane_d.strb_n = 1'b0;
                    lane_d.dat    = 1'b0;
                    lane_d.sh     = result_i;
                    lane_d.left   = len_w;
                    lane_d.gap2   = 1'b0;
                end else begin
                    lane_d.st = ST_IDLE;
                end
            end
            default: lane_d = lane_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lane_q        <= '0;
            lane_q.st     <= ST_IDLE;
            lane_q.strb_n <= 1'b1;
        end else begin
            lane_q <= lane_d;
        end
    end

    a_r8_data_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        strb_n_o |-> !dat_o);

    a_r2_start_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && ready_o) |=> (!strb_n_o && !dat_o));

    a_r2_no_spurious_frame: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(strb_n_o) |-> $past(valid_i && ready_o));

    a_r5_gap_two: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(strb_n_o) |=> strb_n_o);

    a_r6_ready_only_high_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> strb_n_o);

    a_r4_len_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_q.st == ST_TAG) |-> (lane_q.left >= CNT_W'(STEP) && lane_q.left <= CNT_W'(RES_W)));
endmodule

// File: rtl/rs_frame_tx.sv
module rs_frame_tx #(
    parameter int NUM_CH = 4,
    parameter int RES_W  = 40,
    parameter int CODE_W = 3,
    parameter int STEP   = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_CH-1:0]          in_valid,
    output logic [NUM_CH-1:0]          in_ready,
    input  logic [NUM_CH*RES_W-1:0]    in_result,
    input  logic [NUM_CH*CODE_W-1:0]   in_len,
    output logic [NUM_CH-1:0]          ser_strobe_n,
    output logic [NUM_CH-1:0]          ser_data
);
    // R9: one fully separate lane per channel; only the clock and reset are shared.
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_lane
        rs_lane #(
            .RES_W (RES_W),
            .CODE_W(CODE_W),
            .STEP  (STEP)
        ) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .valid_i (in_valid[ch]),
            .ready_o (in_ready[ch]),
            .result_i(in_result[ch*RES_W +: RES_W]),
            .code_i  (in_len[ch*CODE_W +: CODE_W]),
            .strb_n_o(ser_strobe_n[ch]),
            .dat_o   (ser_data[ch])
        );
    end
endmodule

// File: tb/rs_frame_tx_bench.sv
module rs_frame_tx_bench;
    localparam int NCH = 4;
    localparam int RW  = 40;
    localparam int CW  = 3;

    logic           clk = 1'b0;
    logic           rst_n;
    logic [NCH-1:0] vld;
    logic [NCH-1:0] rdy;
    logic [NCH*RW-1:0] res;
    logic [NCH*CW-1:0] lcode;
    logic [NCH-1:0] sn;
    logic [NCH-1:0] sd;

    int total = 0;
    int bad   = 0;
    bit run   = 0;
    bit done  = 0;
    int vprob [NCH];

    logic [RW-1:0] q_val [NCH][$];
    int            q_len [NCH][$];
    bit            in_fr [NCH];
    int            bpos  [NCH];
    logic [RW-1:0] rx    [NCH];
    int            hi    [NCH];
    bit            seen  [NCH];

    always #5 clk = ~clk;

    rs_frame_tx u_rs_frame_tx (
        .clk(clk), .rst_n(rst_n), .in_valid(vld), .in_ready(rdy),
        .in_result(res), .in_len(lcode), .ser_strobe_n(sn), .ser_data(sd)
    );

    function automatic int len_model(input int code);
        return (code < 4) ? 8 * (code + 1) : 40;   // R4
    endfunction

    function automatic logic [RW-1:0] mask_of(input int len);
        return (len >= RW) ? {RW{1'b1}} : ((RW'(1) << len) - RW'(1));
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (run) begin
            for (int c = 0; c < NCH; c++) begin
                // monitor
                if (!sn[c]) begin
                    if (!in_fr[c]) begin
                        chk(q_len[c].size() > 0, "R2 R9 strobe fell with no accepted result", q_len[c].size(), 1);
                        chk(sd[c] == 1'b0, "R2 tag bit", sd[c], 0);
                        if (seen[c]) chk(hi[c] >= 2, "R5 end gap length", hi[c], 2);
                        in_fr[c] = 1'b1;
                        bpos[c]  = 0;
                        rx[c]    = '0;
                    end else begin
                        if (bpos[c] < RW) rx[c][bpos[c]] = sd[c];
                        bpos[c]++;
                    end
                    chk(rdy[c] == 1'b0, "R6 ready low in frame", rdy[c], 0);
                end else begin
                    chk(sd[c] == 1'b0, "R8 data quiet while strobe high", sd[c], 0);
                    if (in_fr[c]) begin
                        in_fr[c] = 1'b0;
                        hi[c]    = 1;
                        seen[c]  = 1'b1;
                        if (q_len[c].size() > 0) begin
                            int            el = q_len[c].pop_front();
                            logic [RW-1:0] ev = q_val[c].pop_front();
                            chk(bpos[c] == el, "R4 R5 field length", bpos[c], el);
                            // R3 bit order and value; R7 inputs were changed every cycle mid-frame
                            chk(rx[c] == (ev & mask_of(el)), "R3 R7 data bits", rx[c], ev & mask_of(el));
                        end
                    end else begin
                        hi[c]++;
                    end
                    chk(rdy[c] == (!seen[c] || hi[c] >= 2), "R6 ready after gap",
                        rdy[c], (!seen[c] || hi[c] >= 2));
                end
                // driver: new inputs every cycle, even while a frame is in flight (R7)
                begin
                    bit            v    = (($urandom % 100) < vprob[c]);
                    int            code = int'($urandom % 8);
                    int            el   = len_model(code);
                    int            sel  = int'($urandom % 4);
                    logic [RW-1:0] val;
                    case (sel)
                        0: val = RW'({$urandom, $urandom});
                        1: val = {RW{1'b1}};
                        2: val = RW'(1) << (el - 1);
                        default: val = '0;
                    endcase
                    vld[c] = v;
                    res[c*RW +: RW]   = val;
                    lcode[c*CW +: CW] = CW'(code);
                    if (v && rdy[c]) begin
                        q_val[c].push_back(val);
                        q_len[c].push_back(el);
                    end
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        rst_n = 1'b0;
        vld   = '0;
        res   = '0;
        lcode = '0;
        for (int c = 0; c < NCH; c++) begin
            vprob[c] = 0; in_fr[c] = 0; bpos[c] = 0; rx[c] = '0; hi[c] = 0; seen[c] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(sn == '1, "R1 strobes high in reset", sn, 4'hF);
        chk(sd == '0, "R1 data low in reset", sd, 0);
        chk(rdy == '1, "R1 ready in reset", rdy, 4'hF);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sn == '1 && sd == '0 && rdy == '1, "R1 idle after reset", {sn, sd, rdy}, 12'hF0F);
        for (int c = 0; c < NCH; c++) vprob[c] = 50;
        run = 1'b1;
        repeat (3000) @(negedge clk);
        // back-to-back on three channels, channel 3 silent (R6, R9)
        vprob[0] = 100; vprob[1] = 100; vprob[2] = 100; vprob[3] = 0;
        repeat (2000) @(negedge clk);
        vprob[0] = 20; vprob[1] = 100; vprob[2] = 0; vprob[3] = 70;
        repeat (2000) @(negedge clk);
        for (int c = 0; c < NCH; c++) vprob[c] = 0;
        repeat (100) @(negedge clk);
        for (int c = 0; c < NCH; c++) begin
            chk(q_len[c].size() == 0, "R2 every accepted result was framed", q_len[c].size(), 0);
            chk(!in_fr[c], "R5 frame finished", in_fr[c], 0);
        end
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule